// File: doc/BRIEF.md
# Synchronous Transfer Negotiation Responder

This block answers an initiator's request to move data synchronously on a parallel peripheral bus. When a request arrives with the initiator's proposed period byte and offset byte, the block picks one of three outcomes: fast synchronous, slow synchronous, or plain asynchronous. It stores the result for the target that is currently addressed and then sends back a five-byte extended reply, one byte per valid/ready handshake.

After the reply has gone out, the block waits to learn whether the initiator agrees. If a reject message arrives, the stored pair for that target goes back to asynchronous. If the exchange ends with attention deasserted, the agreement stands. A bus reset, or a device-reset message, returns every target to asynchronous. A data-phase engine reads the stored period and offset for the selected target.

The sequencer has seven named states. `ST_IDLE` waits for a request and moves to `ST_EXT` when one arrives. `ST_EXT`, `ST_LEN`, `ST_CODE`, `ST_PER` and `ST_OFF` each present one reply byte, and each moves to the next state only on a handshake. `ST_OFF` moves to `ST_AWAIT` when its byte is taken. `ST_AWAIT` returns to `ST_IDLE` on a reject (the "revert" transition) or on an exchange end with attention low (the "accept" transition). A clear from any state returns to `ST_IDLE`.

Top module: `nego_responder`

## Requirements
- R1: A request whose period byte is above 50 stores period 0 and offset 0 (asynchronous), whatever offset was asked for.
- R2: A request whose period byte is 25 or less stores period 25.
- R3: A request whose period byte is from 26 to 50 stores period 50.
- R4: For a synchronous outcome the stored offset is the requested offset, limited to at most 15.
- R5: The reply is the bytes 0x01, 0x03, 0x01, stored period, stored offset, in that order. `rep_valid` stays high and `rep_data` stays unchanged until `rep_ready` is seen high at a clock edge.
- R6: `rep_done` is high for exactly the one cycle after the fifth byte is taken, and `neg_pending` is high from that cycle on.
- R7: Message byte 0x05 received while `neg_pending` is high sets the negotiated target's period and offset to 0 and clears `neg_pending`.
- R8: `xfer_end` with `atn` low while pending clears `neg_pending` and keeps the stored pair. With `atn` high, `neg_pending` stays set.
- R9: `bus_rst`, or message byte 0x0C, sets period and offset to 0 for every target and returns the sequencer to idle in the next cycle.
- R10: Each target ID has its own pair, which `sel_period` and `sel_offset` show for `tgt_id`. A request made while the sequencer is not idle is ignored.
- R11: A 0x05 message while not pending changes no stored pair.
- R12: The stored pair is written at the clock edge that accepts the request, so it is visible before the reply starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rst | input | 1 | Bus reset pulse, clears all targets |
| tgt_id | input | 3 | Current target; selects the readout and the entry that is written |
| req_valid | input | 1 | Synchronous transfer request strobe |
| req_period | input | 8 | Requested period byte |
| req_offset | input | 8 | Requested offset byte |
| msg_valid | input | 1 | Single-byte message strobe |
| msg_byte | input | 8 | Message code (0x05 reject, 0x0C device reset) |
| xfer_end | input | 1 | Message exchange finished |
| atn | input | 1 | Attention line level at exchange end |
| rep_valid | output | 1 | Reply byte valid |
| rep_data | output | 8 | Reply byte |
| rep_ready | input | 1 | Reply byte consumed |
| rep_done | output | 1 | One-cycle pulse after the last reply byte |
| neg_pending | output | 1 | Awaiting accept or reject |
| sel_period | output | 8 | Stored period for `tgt_id` |
| sel_offset | output | 8 | Stored offset for `tgt_id` |

## Verification
The assertions assume that `rst_n` is low until the inputs hold defined levels. They also assume that a hold check on the reply only applies when no clear (bus reset or 0x0C message) arrives in that same cycle. The bench raises `req_valid` only as a single-cycle strobe. It issues clears only between reply bursts, except for one deliberate clear while pending, so every hold window that the assertions watch is left undisturbed. A behavioural model of the stored pairs and the reply queue is compared against all outputs on every cycle.

// File: rtl/nego_pkg.sv
package nego_pkg;

    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] MSG_EXTENDED  = 8'h01;
    localparam logic [BYTE_W-1:0] EXT_LEN_SYNC  = 8'h03;
    localparam logic [BYTE_W-1:0] EXT_CODE_SYNC = 8'h01;
    localparam logic [BYTE_W-1:0] MSG_REJECT    = 8'h05;
    localparam logic [BYTE_W-1:0] MSG_DEV_RESET = 8'h0C;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EXT,
        ST_LEN,
        ST_CODE,
        ST_PER,
        ST_OFF,
        ST_AWAIT
    } nego_state_e;

    typedef struct packed {
        logic [BYTE_W-1:0] period;
        logic [BYTE_W-1:0] offset;
    } xfer_agree_t;

endpackage

// File: rtl/nego_decide.sv
module nego_decide
    import nego_pkg::*;
#(
    parameter int FAST_PERIOD = 25,
    parameter int SLOW_PERIOD = 50,
    parameter int MAX_OFFSET  = 15
) (
    input  logic [BYTE_W-1:0] req_period,
    input  logic [BYTE_W-1:0] req_offset,
    output xfer_agree_t       agree
);

    localparam logic [BYTE_W-1:0] FAST_B = BYTE_W'(FAST_PERIOD);
    localparam logic [BYTE_W-1:0] SLOW_B = BYTE_W'(SLOW_PERIOD);
    localparam logic [BYTE_W-1:0] OFFS_B = BYTE_W'(MAX_OFFSET);

    logic too_slow;
    logic is_fast;

    always_comb begin
        too_slow = (req_period > SLOW_B);
        is_fast  = (req_period <= FAST_B);
        if (too_slow) begin
            agree.period = '0;
            agree.offset = '0;
        end else begin
            agree.period = is_fast ? FAST_B : SLOW_B;
            agree.offset = (req_offset > OFFS_B) ? OFFS_B : req_offset;
        end
    end

endmodule

// File: rtl/nego_param_store.sv
module nego_param_store
    import nego_pkg::*;
#(
    parameter int NUM_TGT = 8,
    localparam int TGT_W  = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_all,
    input  logic              wr_en,
    input  logic [TGT_W-1:0]  wr_id,
    input  xfer_agree_t       wr_val,
    input  logic              zap_en,
    input  logic [TGT_W-1:0]  zap_id,
    input  logic [TGT_W-1:0]  rd_id,
    output xfer_agree_t       rd_val
);

    xfer_agree_t slot [NUM_TGT];

    for (genvar g = 0; g < NUM_TGT; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot[g] <= '0;
            end else if (clr_all) begin
                slot[g] <= '0;
            end else if (zap_en && (zap_id == TGT_W'(g))) begin
                slot[g] <= '0;
            end else if (wr_en && (wr_id == TGT_W'(g))) begin
                slot[g] <= wr_val;
            end
        end
    end

    always_comb begin
        rd_val = '0;
        for (int i = 0; i < NUM_TGT; i++) begin
            if (rd_id == TGT_W'(i)) begin
                rd_val = slot[i];
            end
        end
    end

endmodule

// File: rtl/nego_reply_fsm.sv
module nego_reply_fsm
    import nego_pkg::*;
#(
    parameter int NUM_TGT = 8,
    localparam int TGT_W  = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_all,
    input  logic              req_valid,
    input  logic [TGT_W-1:0]  req_tgt,
    input  xfer_agree_t       agree_in,
    input  logic              rep_ready,
    input  logic              reject,
    input  logic              xfer_end,
    input  logic              atn,
    output logic              rep_valid,
    output logic [BYTE_W-1:0] rep_data,
    output logic              rep_done,
    output logic              pending,
    output logic              cap_en,
    output logic              zap_en,
    output logic [TGT_W-1:0]  held_tgt
);

    nego_state_e state, state_nx;
    xfer_agree_t held_agree;
    logic        done_q;

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (req_valid) state_nx = ST_EXT;
            ST_EXT:   if (rep_ready) state_nx = ST_LEN;
            ST_LEN:   if (rep_ready) state_nx = ST_CODE;
            ST_CODE:  if (rep_ready) state_nx = ST_PER;
            ST_PER:   if (rep_ready) state_nx = ST_OFF;
            ST_OFF:   if (rep_ready) state_nx = ST_AWAIT;
            ST_AWAIT: begin
                if (reject)                 state_nx = ST_IDLE;
                else if (xfer_end && !atn)  state_nx = ST_IDLE;
            end
            default:  state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       state <= ST_IDLE;
        else if (clr_all) state <= ST_IDLE;
        else              state <= state_nx;
    end

    // captured reply content and done pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_agree <= '0;
            held_tgt   <= '0;
            done_q     <= 1'b0;
        end else begin
            if (cap_en) begin
                held_agree <= agree_in;
                held_tgt   <= req_tgt;
            end
            done_q <= (state == ST_OFF) && rep_ready && !clr_all;
        end
    end

    // outputs
    always_comb begin
        rep_valid = 1'b0;
        rep_data  = '0;
        pending   = 1'b0;
        cap_en    = 1'b0;
        zap_en    = 1'b0;
        unique case (state)
            ST_IDLE:  cap_en = req_valid && !clr_all;
            ST_EXT:   begin rep_valid = 1'b1; rep_data = MSG_EXTENDED;      end
            ST_LEN:   begin rep_valid = 1'b1; rep_data = EXT_LEN_SYNC;      end
            ST_CODE:  begin rep_valid = 1'b1; rep_data = EXT_CODE_SYNC;     end
            ST_PER:   begin rep_valid = 1'b1; rep_data = held_agree.period; end
            ST_OFF:   begin rep_valid = 1'b1; rep_data = held_agree.offset; end
            ST_AWAIT: begin
                pending = 1'b1;
                zap_en  = reject && !clr_all;
            end
            default:  ;
        endcase
    end

    assign rep_done = done_q;

endmodule

// File: rtl/nego_responder.sv
module nego_responder
    import nego_pkg::*;
#(
    parameter int NUM_TGT     = 8,
    parameter int FAST_PERIOD = 25,
    parameter int SLOW_PERIOD = 50,
    parameter int MAX_OFFSET  = 15,
    localparam int TGT_W      = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rst,
    input  logic [TGT_W-1:0]  tgt_id,
    input  logic              req_valid,
    input  logic [BYTE_W-1:0] req_period,
    input  logic [BYTE_W-1:0] req_offset,
    input  logic              msg_valid,
    input  logic [BYTE_W-1:0] msg_byte,
    input  logic              xfer_end,
    input  logic              atn,
    output logic              rep_valid,
    output logic [BYTE_W-1:0] rep_data,
    input  logic              rep_ready,
    output logic              rep_done,
    output logic              neg_pending,
    output logic [BYTE_W-1:0] sel_period,
    output logic [BYTE_W-1:0] sel_offset
);

    logic        clr_all;
    logic        reject;
    logic        cap_en;
    logic        zap_en;
    logic [TGT_W-1:0] held_tgt;
    xfer_agree_t agree;
    xfer_agree_t rd_val;

    assign clr_all = bus_rst || (msg_valid && (msg_byte == MSG_DEV_RESET));
    assign reject  = msg_valid && (msg_byte == MSG_REJECT);

    nego_decide #(
        .FAST_PERIOD (FAST_PERIOD),
        .SLOW_PERIOD (SLOW_PERIOD),
        .MAX_OFFSET  (MAX_OFFSET)
    ) u_decide (
        .req_period (req_period),
        .req_offset (req_offset),
        .agree      (agree)
    );

    nego_reply_fsm #(
        .NUM_TGT (NUM_TGT)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_all   (clr_all),
        .req_valid (req_valid),
        .req_tgt   (tgt_id),
        .agree_in  (agree),
        .rep_ready (rep_ready),
        .reject    (reject),
        .xfer_end  (xfer_end),
        .atn       (atn),
        .rep_valid (rep_valid),
        .rep_data  (rep_data),
        .rep_done  (rep_done),
        .pending   (neg_pending),
        .cap_en    (cap_en),
        .zap_en    (zap_en),
        .held_tgt  (held_tgt)
    );

    nego_param_store #(
        .NUM_TGT (NUM_TGT)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_all (clr_all),
        .wr_en   (cap_en),
        .wr_id   (tgt_id),
        .wr_val  (agree),
        .zap_en  (zap_en),
        .zap_id  (held_tgt),
        .rd_id   (tgt_id),
        .rd_val  (rd_val)
    );

    assign sel_period = rd_val.period;
    assign sel_offset = rd_val.offset;

endmodule

// File: rtl/nego_checker.sv
module nego_checker
    import nego_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_rst,
    input logic              msg_valid,
    input logic [BYTE_W-1:0] msg_byte,
    input logic              rep_valid,
    input logic [BYTE_W-1:0] rep_data,
    input logic              rep_ready,
    input logic              rep_done,
    input logic              neg_pending,
    input logic [BYTE_W-1:0] sel_period,
    input logic [BYTE_W-1:0] sel_offset
);

    logic clr_now;
    assign clr_now = bus_rst || (msg_valid && (msg_byte == MSG_DEV_RESET));

    AST_PERIOD_ASYNC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_period == '0) |-> (sel_offset == '0)); // R1

    AST_PERIOD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_period == 8'd0) || (sel_period == 8'd25) || (sel_period == 8'd50)); // R2

    AST_OFFSET_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        sel_offset <= 8'd15); // R4

    AST_REPLY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rep_valid && !rep_ready && !clr_now) |=> (rep_valid && $stable(rep_data))); // R5

    AST_DONE_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rep_done) |-> ($past(rep_valid && rep_ready) && neg_pending)); // R6

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rep_done |=> !rep_done); // R6

    AST_REJECT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (neg_pending && msg_valid && (msg_byte == MSG_REJECT)) |=> !neg_pending); // R7

    AST_CLEAR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        clr_now |=> (!neg_pending && !rep_valid && !rep_done)); // R9

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(rep_valid && neg_pending)); // R10

endmodule

bind nego_responder nego_checker i_nego_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_rst     (bus_rst),
    .msg_valid   (msg_valid),
    .msg_byte    (msg_byte),
    .rep_valid   (rep_valid),
    .rep_data    (rep_data),
    .rep_ready   (rep_ready),
    .rep_done    (rep_done),
    .neg_pending (neg_pending),
    .sel_period  (sel_period),
    .sel_offset  (sel_offset)
);

// File: tb/test_nego_responder.sv
`timescale 1ns/1ps
module test_nego_responder;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_rst = 1'b0;
    logic [2:0] tgt_id = '0;
    logic       req_valid = 1'b0;
    logic [7:0] req_period = '0;
    logic [7:0] req_offset = '0;
    logic       msg_valid = 1'b0;
    logic [7:0] msg_byte = '0;
    logic       xfer_end = 1'b0;
    logic       atn = 1'b0;
    logic       rep_ready = 1'b0;
    logic       rep_valid;
    logic [7:0] rep_data;
    logic       rep_done;
    logic       neg_pending;
    logic [7:0] sel_period;
    logic [7:0] sel_offset;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    nego_responder i_nego_responder (
        .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .tgt_id(tgt_id),
        .req_valid(req_valid), .req_period(req_period), .req_offset(req_offset),
        .msg_valid(msg_valid), .msg_byte(msg_byte), .xfer_end(xfer_end), .atn(atn),
        .rep_valid(rep_valid), .rep_data(rep_data), .rep_ready(rep_ready),
        .rep_done(rep_done), .neg_pending(neg_pending),
        .sel_period(sel_period), .sel_offset(sel_offset)
    );

    // ---------------- reference model ----------------
    int m_per [8];
    int m_off [8];
    int m_step = 0;          // 0 idle, 1..5 byte index, 6 awaiting
    int m_tgt = 0;
    int m_done = 0;
    int m_bytes [5];

    function automatic int rule_period(int p);
        if (p > 50) return 0;
        if (p <= 25) return 25;
        return 50;
    endfunction

    function automatic int rule_offset(int p, int o);
        if (p > 50) return 0;
        return (o > 15) ? 15 : o;
    endfunction

    always @(posedge clk) begin
        if (!rst_n || bus_rst || (msg_valid && msg_byte == 8'h0C)) begin
            for (int i = 0; i < 8; i++) begin m_per[i] = 0; m_off[i] = 0; end
            m_step = 0;
            m_done = 0;
        end else begin
            m_done = 0;
            if (m_step == 0) begin
                if (req_valid) begin
                    m_tgt = tgt_id;
                    m_per[m_tgt] = rule_period(req_period);
                    m_off[m_tgt] = rule_offset(req_period, req_offset);
                    m_bytes[0] = 1; m_bytes[1] = 3; m_bytes[2] = 1;
                    m_bytes[3] = m_per[m_tgt]; m_bytes[4] = m_off[m_tgt];
                    m_step = 1;
                end
            end else if (m_step <= 5) begin
                if (rep_ready) begin
                    if (m_step == 5) begin m_step = 6; m_done = 1; end
                    else m_step = m_step + 1;
                end
            end else begin
                if (msg_valid && msg_byte == 8'h05) begin
                    m_per[m_tgt] = 0; m_off[m_tgt] = 0; m_step = 0;
                end else if (xfer_end && !atn) begin
                    m_step = 0;
                end
            end
        end
    end

    task automatic check_eq(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, cycles, act, exp);
        end
    endtask

    // per-cycle comparison, away from the clock edge
    logic [7:0] got_q [$];
    always @(negedge clk) begin
        #1;
        cycles++;
        if (rst_n) begin
            check_eq("R5 rep_valid", rep_valid, (m_step >= 1 && m_step <= 5));
            if (m_step >= 1 && m_step <= 5) check_eq("R5 rep_data", rep_data, m_bytes[m_step-1]);
            check_eq("R6 rep_done", rep_done, m_done);
            check_eq("R8 neg_pending", neg_pending, (m_step == 6));
            check_eq("R10 sel_period", sel_period, m_per[tgt_id]);
            check_eq("R4 sel_offset", sel_offset, m_off[tgt_id]);
            if (rep_valid && rep_ready) got_q.push_back(rep_data);
        end
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic negotiate(int tgt, int p, int o, bit stall);
        @(negedge clk);
        tgt_id = 3'(tgt); req_period = 8'(p); req_offset = 8'(o); req_valid = 1'b1;
        got_q.delete();
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 14; i++) begin
            rep_ready = stall ? ((i % 2) == 1) : 1'b1;
            @(negedge clk);
        end
        rep_ready = 1'b0;
    endtask

    task automatic send_msg(int code);
        @(negedge clk);
        msg_valid = 1'b1; msg_byte = 8'(code);
        @(negedge clk);
        msg_valid = 1'b0;
    endtask

    task automatic end_xfer(bit a);
        @(negedge clk);
        xfer_end = 1'b1; atn = a;
        @(negedge clk);
        xfer_end = 1'b0; atn = 1'b0;
    endtask

    task automatic check_reply(string tag, int p, int o);
        check_eq({tag, " reply length"}, got_q.size(), 5);
        if (got_q.size() == 5) begin
            check_eq({tag, " byte0"}, got_q[0], 1);
            check_eq({tag, " byte1"}, got_q[1], 3);
            check_eq({tag, " byte2"}, got_q[2], 1);
            check_eq({tag, " period byte"}, got_q[3], rule_period(p));
            check_eq({tag, " offset byte"}, got_q[4], rule_offset(p, o));
        end
    endtask

    task automatic peek(int tgt, string tag, int p, int o);
        @(negedge clk);
        tgt_id = 3'(tgt);
        #1;
        check_eq({tag, " period"}, sel_period, p);
        check_eq({tag, " offset"}, sel_offset, o);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check_eq("R9 reset period", sel_period, 0);
        check_eq("R9 reset pending", neg_pending, 0);

        // R2 + R4: fast, offset clamped; accepted
        negotiate(0, 10, 20, 1'b0);
        check_reply("R5 fast", 10, 20);
        peek(0, "R2 fast", 25, 15);
        end_xfer(1'b0);
        check_eq("R8 accepted pending", neg_pending, 0);
        peek(0, "R8 kept", 25, 15);

        // R3 with stalls; atn high keeps pending, then reject reverts
        negotiate(1, 30, 8, 1'b1);
        check_reply("R5 stalled", 30, 8);
        peek(1, "R3 slow", 50, 8);
        end_xfer(1'b1);
        check_eq("R8 atn keeps pending", neg_pending, 1);
        send_msg(8'h05);
        peek(1, "R7 reverted", 0, 0);
        peek(0, "R10 other target intact", 25, 15);

        // R1: too slow
        negotiate(2, 51, 5, 1'b0);
        check_reply("R1 async", 51, 5);
        peek(2, "R1 async", 0, 0);
        // R10: request while pending is ignored
        @(negedge clk); tgt_id = 3'd5; req_period = 8'd10; req_offset = 8'd3; req_valid = 1'b1;
        @(negedge clk); req_valid = 1'b0;
        peek(5, "R10 busy ignore", 0, 0);
        end_xfer(1'b0);

        // boundaries
        negotiate(3, 25, 15, 1'b0); peek(3, "R2 boundary 25", 25, 15); end_xfer(1'b0);
        negotiate(4, 26, 16, 1'b0); peek(4, "R3 boundary 26", 50, 15); end_xfer(1'b0);
        negotiate(6, 50, 0, 1'b1);  peek(6, "R3 boundary 50", 50, 0);  end_xfer(1'b0);

        // R11: reject while idle has no effect
        send_msg(8'h05);
        peek(3, "R11 idle reject", 25, 15);

        // R12: pair visible while reply still in progress
        @(negedge clk); tgt_id = 3'd7; req_period = 8'd20; req_offset = 8'd4; req_valid = 1'b1;
        @(negedge clk); req_valid = 1'b0; #1;
        check_eq("R12 early period", sel_period, 25);
        check_eq("R12 early offset", sel_offset, 4);
        for (int i = 0; i < 6; i++) begin rep_ready = 1'b1; @(negedge clk); end
        rep_ready = 1'b0;

        // R9: device reset message while pending clears all
        send_msg(8'h0C);
        check_eq("R9 msg reset pending", neg_pending, 0);
        for (int t = 0; t < 8; t++) peek(t, "R9 msg reset", 0, 0);

        // R9: bus reset
        negotiate(0, 12, 9, 1'b0);
        end_xfer(1'b0);
        @(negedge clk); bus_rst = 1'b1;
        @(negedge clk); bus_rst = 1'b0;
        peek(0, "R9 bus reset", 0, 0);

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule